// File: doc/BRIEF.md
# DMA Channel Enable and Transfer-End Control

This block is the control and status core of a single DMA channel. It keeps a channel enable, an interrupt enable, a request-mode select, a transfer-end flag and a down-counter of remaining transfers. From these and from the chip-wide master enable and NMI flag it decides, cycle by cycle, whether the channel may issue a bus transfer. The bus master reports each finished transfer with a one-cycle beat-done pulse.

Software loads the count, then sets the enable. In auto-request mode the channel starts issuing transfers at once. In external-request mode it issues one transfer for each request pulse that arrives while it is permitted to run. When the last counted transfer completes, the end flag is set and, if interrupts are enabled, an interrupt request is raised. Aborts never set the end flag, and the counter keeps the transfers still owed. The abort sources are master disable, NMI, an address error and software clearing the enable. The end flag stays set until software reads it as 1 and then writes 0 to it. While it is set, the channel stays stopped.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the count register (address 1) read 0, and `xfer_active_o` and `irq_o` are 0.
- R2: Control register layout: bit 0 channel enable, bit 1 transfer-end flag, bit 2 interrupt enable, bit 3 request mode (0 auto, 1 external). Address 1 holds the remaining count. In auto mode, `xfer_active_o` is 1 from the cycle after the enable is written, provided the count is nonzero, the master enable is 1 and NMI is 0.
- R3: In external mode, `xfer_active_o` rises in the cycle after an `ext_req_i` pulse that arrives while the channel is permitted. It falls after the matching beat-done. A request that arrives while the channel is disabled is ignored.
- R4: Each `beat_done_i` pulse seen while `xfer_active_o` is 1 decrements the count by one.
- R5: When the count goes from 1 to 0, the end flag is set and `xfer_active_o` is 0 from the next cycle.
- R6: `irq_o` is 1 exactly when the end flag and the interrupt enable are both 1.
- R7: `master_en_i` low or `nmi_flag_i` high forces `xfer_active_o` to 0 in the same cycle. Beat-done pulses during that time leave the count unchanged, and the end flag is not set.
- R8: An `addr_err_i` pulse forces `xfer_active_o` to 0 in that cycle and clears the channel enable. The end flag is not set.
- R9: Writing 0 to the channel enable stops transfers. The count is kept and the end flag is not set.
- R10: The end flag is cleared only by a write of 0 to bit 1 that follows a read of the control register returning the flag as 1. Writing 1, or writing 0 without that read, leaves it unchanged.
- R11: While the end flag is 1, `xfer_active_o` stays 0 even with the channel enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the addressed register (combinational) |
| master_en_i | input | 1 | Global DMA master enable |
| nmi_flag_i | input | 1 | Global NMI flag |
| addr_err_i | input | 1 | Address error pulse |
| ext_req_i | input | 1 | External or peripheral request pulse |
| beat_done_i | input | 1 | One transfer completed |
| xfer_active_o | output | 1 | Channel may issue a transfer |
| irq_o | output | 1 | Transfer-end interrupt request |

## Verification
The hardest state to reach is the end flag at 1 with the enable also at 1 and no read yet taken. The bench gets there by running a full counted transfer. It then writes 0 to the flag without a prior read, and shows that the flag holds and the channel stays blocked. A read followed by the same write then clears the flag. The bench places aborts partway through a count while beat-done pulses keep arriving. This shows that the remaining count survives and that no end flag appears.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CNT  = 1;
  localparam int unsigned BIT_EN    = 0;
  localparam int unsigned BIT_END   = 1;
  localparam int unsigned BIT_IE    = 2;
  localparam int unsigned BIT_MODE  = 3;

  typedef enum logic {
    MODE_AUTO = 1'b0,
    MODE_EXT  = 1'b1
  } req_mode_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_re_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tc_i,
  input  logic              addr_err_i,
  output logic              chan_en_o,
  output logic              end_flag_o,
  output logic              irq_en_o,
  output req_mode_e         mode_o
);
  logic en_q, end_q, ie_q, seen_q;
  req_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      end_q  <= 1'b0;
      ie_q   <= 1'b0;
      seen_q <= 1'b0;
      mode_q <= MODE_AUTO;
    end else begin
      if (ctrl_we_i) begin
        en_q   <= wdata_i[BIT_EN];
        ie_q   <= wdata_i[BIT_IE];
        mode_q <= req_mode_e'(wdata_i[BIT_MODE]);
      end
      if (addr_err_i) en_q <= 1'b0;
      // read-as-1 arms the clear; a write consumes it
      if (ctrl_we_i) begin
        seen_q <= 1'b0;
        if (!wdata_i[BIT_END] && seen_q) end_q <= 1'b0;
      end else if (ctrl_re_i && end_q) begin
        seen_q <= 1'b1;
      end
      if (tc_i) end_q <= 1'b1;
    end
  end

  assign chan_en_o  = en_q;
  assign end_flag_o = end_q;
  assign irq_en_o   = ie_q;
  assign mode_o     = mode_q;

  AST_END_ONLY_ON_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_q) |-> $past(tc_i)); // R5
  AST_END_CLEAR_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(end_q) |-> $past(ctrl_we_i && !wdata_i[BIT_END] && seen_q)); // R10
  AST_ADDR_ERR_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_i |=> !en_q); // R8
endmodule

// File: rtl/dma_chan_count.sv
module dma_chan_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             beat_i,
  input  logic             active_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nonzero_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;
  logic dec;

  assign dec = beat_i && active_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec)     cnt_q <= cnt_q - ONE;
  end

  assign cnt_o     = cnt_q;
  assign nonzero_o = |cnt_q;
  assign tc_o      = dec && (cnt_q == ONE);

  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && active_i && !load_i) |=> cnt_q == $past(cnt_q) - ONE); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !load_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/dma_chan_gate.sv
module dma_chan_gate
  import dma_chan_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      chan_en_i,
  input  logic      end_flag_i,
  input  logic      master_en_i,
  input  logic      nmi_i,
  input  logic      addr_err_i,
  input  req_mode_e mode_i,
  input  logic      ext_req_i,
  input  logic      beat_i,
  input  logic      nonzero_i,
  output logic      active_o
);
  logic permit, pend_q, want;

  assign permit = chan_en_i && !end_flag_i && master_en_i && !nmi_i && !addr_err_i;
  assign want   = (mode_i == MODE_AUTO) ? 1'b1 : pend_q;
  assign active_o = permit && nonzero_i && want;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pend_q <= 1'b0;
    else if (!permit)              pend_q <= 1'b0;
    else if (ext_req_i)            pend_q <= 1'b1;
    else if (beat_i && active_o)   pend_q <= 1'b0;
  end

  AST_ACTIVE_NEEDS_PERMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (chan_en_i && !end_flag_i)); // R11
  AST_ABORT_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_en_i || nmi_i) |-> !active_o); // R7
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              master_en_i,
  input  logic              nmi_flag_i,
  input  logic              addr_err_i,
  input  logic              ext_req_i,
  input  logic              beat_done_i,
  output logic              xfer_active_o,
  output logic              irq_o
);
  logic sel_ctrl, sel_cnt;
  logic chan_en, end_flag, irq_en, nonzero, tc, active;
  req_mode_e mode;
  logic [CNT_W-1:0] cnt;

  assign sel_ctrl = (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign sel_cnt  = (reg_addr_i == ADDR_W'(ADDR_CNT));

  dma_chan_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (reg_we_i && sel_ctrl),
    .ctrl_re_i  (reg_re_i && sel_ctrl),
    .wdata_i    (reg_wdata_i),
    .tc_i       (tc),
    .addr_err_i (addr_err_i),
    .chan_en_o  (chan_en),
    .end_flag_o (end_flag),
    .irq_en_o   (irq_en),
    .mode_o     (mode)
  );

  dma_chan_count #(.CNT_W(CNT_W)) i_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (reg_we_i && sel_cnt),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .beat_i     (beat_done_i),
    .active_i   (active),
    .cnt_o      (cnt),
    .nonzero_o  (nonzero),
    .tc_o       (tc)
  );

  dma_chan_gate i_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_en_i   (chan_en),
    .end_flag_i  (end_flag),
    .master_en_i (master_en_i),
    .nmi_i       (nmi_flag_i),
    .addr_err_i  (addr_err_i),
    .mode_i      (mode),
    .ext_req_i   (ext_req_i),
    .beat_i      (beat_done_i),
    .nonzero_i   (nonzero),
    .active_o    (active)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl) begin
      reg_rdata_o[BIT_EN]   = chan_en;
      reg_rdata_o[BIT_END]  = end_flag;
      reg_rdata_o[BIT_IE]   = irq_en;
      reg_rdata_o[BIT_MODE] = mode;
    end else if (sel_cnt) begin
      reg_rdata_o[CNT_W-1:0] = cnt;
    end
  end

  assign xfer_active_o = active;
  assign irq_o         = end_flag && irq_en;

  AST_IRQ_NEEDS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> end_flag); // R6
  AST_IDLE_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_flag |-> !xfer_active_o); // R11
endmodule

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic we = 0, re = 0, master = 1, nmi = 0, aerr = 0, ereq = 0, beat = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic active, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl i_dma_chan_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .master_en_i(master), .nmi_flag_i(nmi),
    .addr_err_i(aerr), .ext_req_i(ereq), .beat_done_i(beat),
    .xfer_active_o(active), .irq_o(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1; addr = 2'(a); wdata = DW'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); re = 1; addr = 2'(a); #1 d = int'(rdata);
    @(negedge clk); re = 0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, cyc;
    #(CLK_PERIOD*2+2) rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 cnt", v, 0);
    chk("R1 active", int'(active), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 R4 R5 R6 auto sweep
    for (int n = 1; n <= 6; n++) begin
      int ie = n % 2;
      wr(1, n);
      wr(0, 1 | (ie << 2));
      chk("R2 auto start", int'(active), 1);
      cyc = 0;
      for (int k = 0; k < 20; k++) begin
        if (!active) break;
        cyc++; beat = 1;
        @(negedge clk); beat = 0;
      end
      chk("R5 beats", cyc, n);
      rd(1, v); chk("R4 cnt zero", v, 0);
      rd(0, v); chk("R5 end set", (v >> 1) & 1, 1);
      chk("R6 irq", int'(irq), ie);
      wr(0, 1 | (ie << 2) | 2);           // write 1: no effect
      // that write consumed the read arm; write 0 with no read
      wr(0, 1 | (ie << 2));
      rd(0, v); chk("R10 no clear", (v >> 1) & 1, 1);
      chk("R11 blocked", int'(active), 0);
      wr(1, 2);
      chk("R11 still blocked", int'(active), 0);
      wr(0, 1 | (ie << 2));               // cleared after read as 1
      chk("R10 cleared", int'(active), 1);
      rd(0, v); chk("R10 flag 0", (v >> 1) & 1, 0);
      chk("R6 irq low", int'(irq), 0);
      wr(0, 0);
    end

    // R3 external mode
    @(negedge clk); ereq = 1; @(negedge clk); ereq = 0;   // while disabled
    wr(1, 3);
    wr(0, 1 | 8);
    repeat (3) @(negedge clk);
    chk("R3 early req ignored", int'(active), 0);
    for (int k = 3; k >= 1; k--) begin
      ereq = 1; @(negedge clk); ereq = 0;
      chk("R3 active on req", int'(active), 1);
      beat = 1; @(negedge clk); beat = 0;
      chk("R3 one beat per req", int'(active), 0);
      rd(1, v); chk("R4 ext cnt", v, k - 1);
    end
    rd(0, v); chk("R5 ext end", (v >> 1) & 1, 1);
    wr(0, 0);

    // R7 master disable and NMI
    wr(1, 10);
    wr(0, 1);
    beat = 1; repeat (2) @(negedge clk);
    master = 0; #1 chk("R7 master same cycle", int'(active), 0);
    repeat (2) @(negedge clk);
    master = 1; nmi = 1; #1 chk("R7 nmi same cycle", int'(active), 0);
    repeat (2) @(negedge clk);
    beat = 0; nmi = 0;
    rd(1, v); chk("R7 cnt held", v, 8);
    rd(0, v); chk("R7 no end", (v >> 1) & 1, 0);
    chk("R7 resume", int'(active), 1);

    // R8 address error
    aerr = 1; #1 chk("R8 same cycle", int'(active), 0);
    @(negedge clk); aerr = 0;
    rd(0, v); chk("R8 en cleared", v & 3, 0);
    rd(1, v); chk("R8 cnt held", v, 8);

    // R9 software disable
    wr(0, 1);
    beat = 1; @(negedge clk); beat = 0;
    wr(0, 0);
    chk("R9 stopped", int'(active), 0);
    rd(1, v); chk("R9 cnt held", v, 7);
    rd(0, v); chk("R9 no end", (v >> 1) & 1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule